// File: doc/BRIEF.md
# Search-Pass Nibble Accelerator

This engine speeds up the bit-by-bit device discovery on a single-wire open-drain bus. Software hands it one byte at a time. Each byte carries four direction decisions for four consecutive ID bit positions. For every position the engine asks the bus layer for two read slots and then one write slot, and it picks the write value from what it read. After the fourth write it returns one byte. That byte holds the four ID bits it found and, next to each one, a flag. The flag is set where the devices disagreed or where no device answered.

A full discovery pass covers 64 bit positions, which is 16 bytes out and 16 bytes back. The engine talks to the bus through a slot-level request/acknowledge pair. It holds a request until the bus layer reports that the slot has finished, and on a read slot it takes the sampled bit. The engine is switched on by a rising edge of an enable request. It refuses that edge while an unread result byte is waiting. A missing response puts the engine into a sticky error mode, and only dropping the enable leaves it.

Top module: `srch_accel`

## Requirements
- R1: After reset, accel_on, tx_ready, slot_req, rx_valid, rx_full and err_flag are all 0.
- R2: A rising edge of en_req turns accel_on on one clock later if rx_full is 0. If rx_full is 1 at that edge, the request is refused: accel_on stays 0, even after rx_full clears, until en_req falls and rises again.
- R3: Each bit position uses exactly three slots: read, read, write (slot_wr = 1 only on the write). slot_req stays high until slot_done, and the next bit position starts only after its write slot is done.
- R4: The decision bit for nibble lane i (i = 0..3) is taken from tx_data bit 2i+1. Lane 0 is processed first. tx_data bits 0, 2, 4 and 6 have no effect.
- R5: In rx_data, lane i reports its ID bit at bit 2i+1 and its flag at bit 2i.
- R6: Reads 0 then 1 give write 0, ID 0 and flag 0. Reads 1 then 0 give write 1, ID 1 and flag 0.
- R7: Reads 0 then 0 give a write equal to the lane's decision bit, an ID equal to that bit, and flag 1.
- R8: Reads 1 then 1 give write 1, ID 1 and flag 1, and they set err_flag.
- R9: While err_flag is 1, every later lane writes 1 and reports ID 1 with flag 1, whatever the reads return.
- R10: rx_valid is a one-cycle pulse that comes after the fourth write slot of a byte is done. rx_full goes high with it and stays high until rx_ack. tx_ready is high only while the engine is on and no byte is in progress.
- R11: Dropping en_req aborts any byte in progress with no rx_valid. One clock later slot_req, tx_ready, accel_on and err_flag are 0. The next accepted byte starts again at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_req | input | 1 | Enable request level; its rising edge arms the engine |
| accel_on | output | 1 | Engine is enabled |
| tx_data | input | 8 | Decision byte, four decisions at odd bits |
| tx_valid | input | 1 | tx_data offered |
| tx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_data | output | 8 | Result byte: ID at odd bits, flags at even bits |
| rx_valid | output | 1 | One-cycle pulse, new rx_data |
| rx_full | output | 1 | Unread result is held |
| rx_ack | input | 1 | Result consumed, clears rx_full |
| slot_req | output | 1 | Slot requested, held until slot_done |
| slot_wr | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Value for the write slot |
| slot_done | input | 1 | Requested slot finished |
| slot_rbit | input | 1 | Bit sampled in a finished read slot |
| err_flag | output | 1 | Sticky no-response error |

## Verification
On every cycle the assertions check the control relations. They cover the refused enable, the single-cycle rx_valid and its tie to rx_full, the slot request held until it is acknowledged, a ready engine that issues no slot, the sticky error under an active enable, and the quiet state after the enable drops. Only the scenarios can show the data side. This includes the ID and flag values for each read pair, the lane order and the ignored even bits, the write values the bus layer receives, and the full 64-bit passes over several simulated devices. The scenarios also cover error injection partway through a pass, a bus with no devices, and a restart at lane 0 after an aborted byte.

// File: rtl/srch_pkg.sv
package srch_pkg;
    parameter int LANES = 4;
    localparam int BYTE_W = 2 * LANES;
    localparam int IDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_WR   = 2'd3
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  idx;
        logic [LANES-1:0]  dec;
        logic [BYTE_W-1:0] acc;
        logic              rd1;
        logic              wbit;
        logic              err;
        logic              on;
        logic              en_q;
        logic [BYTE_W-1:0] rxd;
        logic              rxv;
        logic              rxf;
    } state_t;
endpackage

// File: rtl/srch_bit_resolve.sv
module srch_bit_resolve (
    input  logic rd_first,
    input  logic rd_second,
    input  logic dec_bit,
    input  logic err_in,
    output logic wr_bit,
    output logic id_bit,
    output logic flag_bit,
    output logic err_hit
);
    always_comb begin
        wr_bit   = 1'b1;
        id_bit   = 1'b1;
        flag_bit = 1'b1;
        err_hit  = 1'b0;
        if (!err_in) begin
            unique case ({rd_first, rd_second})
                2'b01: begin wr_bit = 1'b0;    id_bit = 1'b0;    flag_bit = 1'b0; end
                2'b10: begin wr_bit = 1'b1;    id_bit = 1'b1;    flag_bit = 1'b0; end
                2'b00: begin wr_bit = dec_bit; id_bit = dec_bit; flag_bit = 1'b1; end
                default: err_hit = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/srch_lane_sel.sv
module srch_lane_sel #(
    parameter int LANES = 4,
    parameter int IDX_W = 2,
    localparam int BYTE_W = 2 * LANES
) (
    input  logic [LANES-1:0]  dec_v,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic              id_bit,
    input  logic              flag_bit,
    output logic              dec_bit,
    output logic [BYTE_W-1:0] acc_out
);
    assign dec_bit = dec_v[idx];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit            = (idx == IDX_W'(g));
        assign acc_out[2*g+1] = hit ? id_bit   : acc_in[2*g+1];
        assign acc_out[2*g]   = hit ? flag_bit : acc_in[2*g];
    end
endmodule

// File: rtl/srch_accel.sv
module srch_accel
    import srch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    output logic              accel_on,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_full,
    input  logic              rx_ack,
    output logic              slot_req,
    output logic              slot_wr,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit,
    output logic              err_flag
);
    state_t q, n;

    logic [LANES-1:0] dec_in;
    logic [LANES-1:0] even_in;
    logic             unused_even;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign dec_in[g]  = tx_data[2*g+1];
        assign even_in[g] = tx_data[2*g];
    end
    assign unused_even = ^even_in;

    logic              cur_dec;
    logic [BYTE_W-1:0] acc_next;
    logic              res_wr, res_id, res_flag, res_err;

    srch_lane_sel #(.LANES(LANES), .IDX_W(IDX_W)) u_lane (
        .dec_v   (q.dec),
        .idx     (q.idx),
        .acc_in  (q.acc),
        .id_bit  (res_id),
        .flag_bit(res_flag),
        .dec_bit (cur_dec),
        .acc_out (acc_next)
    );

    srch_bit_resolve u_res (
        .rd_first (q.rd1),
        .rd_second(slot_rbit),
        .dec_bit  (cur_dec),
        .err_in   (q.err),
        .wr_bit   (res_wr),
        .id_bit   (res_id),
        .flag_bit (res_flag),
        .err_hit  (res_err)
    );

    always_comb begin
        n      = q;
        n.rxv  = 1'b0;
        n.en_q = en_req;
        if (rx_ack) n.rxf = 1'b0;

        if (!en_req) begin
            n.on  = 1'b0;
            n.st  = ST_IDLE;
            n.idx = '0;
            n.err = 1'b0;
            n.acc = '0;
        end else if (!q.on) begin
            if (!q.en_q && !q.rxf) n.on = 1'b1;
        end else begin
            unique case (q.st)
                ST_IDLE: if (tx_valid) begin
                    n.dec = dec_in;
                    n.idx = '0;
                    n.acc = '0;
                    n.st  = ST_RD1;
                end
                ST_RD1: if (slot_done) begin
                    n.rd1 = slot_rbit;
                    n.st  = ST_RD2;
                end
                ST_RD2: if (slot_done) begin
                    n.wbit = res_wr;
                    n.acc  = acc_next;
                    if (res_err) n.err = 1'b1;
                    n.st   = ST_WR;
                end
                ST_WR: if (slot_done) begin
                    if (q.idx == IDX_W'(LANES - 1)) begin
                        n.rxd = q.acc;
                        n.rxv = 1'b1;
                        n.rxf = 1'b1;
                        n.idx = '0;
                        n.st  = ST_IDLE;
                    end else begin
                        n.idx = q.idx + 1'b1;
                        n.st  = ST_RD1;
                    end
                end
                default: n.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign accel_on  = q.on;
    assign tx_ready  = q.on && (q.st == ST_IDLE);
    assign slot_req  = (q.st != ST_IDLE);
    assign slot_wr   = (q.st == ST_WR);
    assign slot_wbit = q.wbit;
    assign rx_data   = q.rxd;
    assign rx_valid  = q.rxv;
    assign rx_full   = q.rxf;
    assign err_flag  = q.err;
endmodule

// File: rtl/srch_accel_chk.sv
module srch_accel_chk (
    input logic clk,
    input logic rst_n,
    input logic en_req,
    input logic accel_on,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_full,
    input logic slot_req,
    input logic slot_done,
    input logic err_flag
);
    a_r2_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accel_on) |-> !$past(rx_full));

    a_r2_on_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        accel_on |-> $past(en_req));

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_done && en_req) |=> slot_req);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && en_req) |=> err_flag);

    a_r10_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r10_valid_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_full);

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !slot_req);

    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |=> (!slot_req && !err_flag && !accel_on));

    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !accel_on |-> (!slot_req && !tx_ready));
endmodule

bind srch_accel srch_accel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .accel_on (accel_on),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_full  (rx_full),
    .slot_req (slot_req),
    .slot_done(slot_done),
    .err_flag (err_flag)
);

// File: tb/srch_accel_bench.sv
`timescale 1ns/1ps
module srch_accel_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0;
    logic accel_on;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [7:0] rx_data;
    logic rx_valid;
    logic rx_full;
    logic rx_ack = 1'b0;
    logic slot_req, slot_wr, slot_wbit;
    logic slot_done = 1'b0;
    logic slot_rbit = 1'b1;
    logic err_flag;

    always #10 clk = ~clk;

    srch_accel u_srch_accel (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .accel_on(accel_on),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full), .rx_ack(rx_ack),
        .slot_req(slot_req), .slot_wr(slot_wr), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit), .err_flag(err_flag)
    );

    int total = 0;
    int bad = 0;
    int rx_seen = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // simulated devices on the bus
    logic [63:0] devs [3];
    logic [2:0]  present = 3'b111;
    int          kill_pos = -1;

    function automatic logic bus_rd(input logic [2:0] act, input int pos, input bit second);
        logic v = 1'b1;
        for (int i = 0; i < 3; i++)
            if (act[i]) v &= second ? ~devs[i][pos] : devs[i][pos];
        return v;
    endfunction

    // slot responder model
    logic [2:0]  m_act;
    int          m_pos = 0;
    int          m_phase = 0;
    logic [63:0] m_wr = '0;

    task automatic model_reset();
        m_act = present; m_pos = 0; m_phase = 0; m_wr = '0;
    endtask

    always begin
        @(negedge clk);
        if (slot_req) begin
            logic w, wb, v;
            w = slot_wr; wb = slot_wbit; v = 1'b1;
            repeat (2) @(negedge clk);
            if (m_phase < 2) begin
                chk(!w, "R3 read slot expected", 64'(w), 64'd0);
                v = (m_pos == kill_pos) ? 1'b1 : bus_rd(m_act, m_pos, m_phase == 1);
                m_phase++;
            end else begin
                chk(w, "R3 write slot expected", 64'(w), 64'd1);
                for (int i = 0; i < 3; i++)
                    if (devs[i][m_pos] != wb) m_act[i] = 1'b0;
                if (m_pos < 64) m_wr[m_pos] = wb;
                m_pos++;
                m_phase = 0;
            end
            slot_rbit = v;
            slot_done = 1'b1;
            @(negedge clk);
            slot_done = 1'b0;
        end
    end

    // expectation model
    logic [2:0] e_act;
    bit         e_err;
    logic [7:0] exp_q [$];

    task automatic exp_reset();
        e_act = present; e_err = 1'b0;
    endtask

    task automatic exp_nib(input int k, input logic [7:0] b, output logic [7:0] e);
        for (int i = 0; i < 4; i++) begin
            int p;
            logic r1, r2, id, d;
            p = 4 * k + i;
            id = 1'b1; d = 1'b1;
            if (!e_err) begin
                r1 = (p == kill_pos) ? 1'b1 : bus_rd(e_act, p, 1'b0);
                r2 = (p == kill_pos) ? 1'b1 : bus_rd(e_act, p, 1'b1);
                case ({r1, r2})
                    2'b01: begin id = 1'b0; d = 1'b0; end
                    2'b10: begin id = 1'b1; d = 1'b0; end
                    2'b00: begin id = b[2*i+1]; d = 1'b1; end
                    default: e_err = 1'b1;
                endcase
            end
            for (int j = 0; j < 3; j++)
                if (devs[j][p] != id) e_act[j] = 1'b0;
            e[2*i+1] = id;
            e[2*i]   = d;
        end
    endtask

    // monitor: pops expected bytes as results appear
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && rx_valid)
                chk(1'b0, "R10 rx_valid longer than one cycle", 64'd1, 64'd0);
            if (rx_valid) begin
                rx_seen++;
                if (exp_q.size() == 0)
                    chk(1'b0, "R11 unexpected rx byte", 64'(rx_data), 64'd0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R4 R5 R6 R7 R8 R9 rx byte", 64'(rx_data), 64'(e));
                end
            end
            prev_v = rx_valid;
        end
    end

    task automatic send_byte(input logic [7:0] b, input int k, input bit ack);
        logic [7:0] e;
        exp_nib(k, b, e);
        exp_q.push_back(e);
        do @(negedge clk); while (!tx_ready);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        do @(negedge clk); while (!rx_valid);
        begin
            logic [3:0] wexp, wact;
            for (int i = 0; i < 4; i++) begin
                wexp[i] = e[2*i+1];
                wact[i] = m_wr[4*k+i];
            end
            chk(wact == wexp, "R6 R7 R9 write values", 64'(wact), 64'(wexp));
        end
        if (ack) begin
            rx_ack = 1'b1;
            @(negedge clk);
            rx_ack = 1'b0;
        end
    endtask

    function automatic logic [7:0] pack(input logic [63:0] dec, input int k, input logic [7:0] xm);
        logic [7:0] b = xm;
        for (int i = 0; i < 4; i++) b[2*i+1] = dec[4*k+i];
        return b;
    endfunction

    task automatic run_bytes(input logic [63:0] dec, input logic [7:0] xm, input int nbytes);
        model_reset();
        exp_reset();
        for (int k = 0; k < nbytes; k++) send_byte(pack(dec, k, xm), k, 1'b1);
    endtask

    task automatic toggle_enable();
        en_req = 1'b0;
        @(negedge clk);
        en_req = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        wrap_up();
    end

    initial begin
        devs[0] = 64'h1122_3344_5566_7788;
        devs[1] = 64'h1122_3344_5566_778C;
        devs[2] = 64'h90AB_00FF_1357_9A61;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({accel_on, tx_ready, slot_req, rx_valid, rx_full, err_flag} == 6'b0,
            "R1 reset outputs",
            64'({accel_on, tx_ready, slot_req, rx_valid, rx_full, err_flag}), 64'd0);

        en_req = 1'b1;
        @(negedge clk);
        chk(accel_on, "R2 enable accepted", 64'(accel_on), 64'd1);
        chk(tx_ready, "R10 ready when idle", 64'(tx_ready), 64'd1);

        // full passes, both decision polarities, even bits set in the second
        run_bytes(64'h0, 8'h00, 16);
        run_bytes(~64'h0, 8'h55, 16);
        run_bytes(64'h0000_0000_0000_0004, 8'hAA, 16);

        // refused enable while a result is unread
        model_reset(); exp_reset();
        send_byte(pack(64'h0, 0, 8'h00), 0, 1'b0);
        chk(rx_full, "R10 rx_full held", 64'(rx_full), 64'd1);
        toggle_enable();
        repeat (2) @(negedge clk);
        chk(!accel_on, "R2 enable refused while full", 64'(accel_on), 64'd0);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        @(negedge clk);
        chk(!rx_full, "R10 rx_ack clears full", 64'(rx_full), 64'd0);
        chk(!accel_on, "R2 stays refused without new edge", 64'(accel_on), 64'd0);
        toggle_enable();
        chk(accel_on, "R2 enable on new edge", 64'(accel_on), 64'd1);

        // no-response injected at bit 10, sticky afterwards
        kill_pos = 10;
        run_bytes(64'h0, 8'h00, 4);
        chk(err_flag, "R8 error latched", 64'(err_flag), 64'd1);
        en_req = 1'b0;
        @(negedge clk);
        chk(!err_flag && !accel_on, "R11 error cleared by disable",
            64'({err_flag, accel_on}), 64'd0);
        kill_pos = -1;
        en_req = 1'b1;
        @(negedge clk);
        run_bytes(64'h0, 8'h00, 2);
        chk(!err_flag, "R9 clean after re-enable", 64'(err_flag), 64'd0);

        // empty bus
        present = 3'b000;
        run_bytes(64'h0, 8'h00, 1);
        chk(err_flag, "R8 empty bus error", 64'(err_flag), 64'd1);
        toggle_enable();
        present = 3'b111;

        // abort partway through a byte
        begin
            int seen0;
            seen0 = rx_seen;
            model_reset();
            do @(negedge clk); while (!tx_ready);
            tx_data = 8'hFF; tx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
            repeat (6) @(negedge clk);
            en_req = 1'b0;
            @(negedge clk);
            chk(!slot_req && !tx_ready, "R11 abort stops slots",
                64'({slot_req, tx_ready}), 64'd0);
            repeat (20) @(negedge clk);
            chk(rx_seen == seen0, "R11 no result after abort", 64'(rx_seen), 64'(seen0));
            en_req = 1'b1;
            @(negedge clk);
            run_bytes(64'h0000_0000_0000_000A, 8'h00, 2);
        end

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all results delivered", 64'(exp_q.size()), 64'd0);
        wrap_up();
    end
endmodule